// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block produces a one-bit playfield video signal for a 228-clock scanline with 160 active pixels. Three stored pattern registers supply the bits. The first register contributes its upper four bits, and the second and third contribute eight bits each, so each half of the active line shows 20 playfield bits. Each bit covers four pixel clocks. A control bit can mirror the right half of the line. Everything runs on the pixel clock. The processor side drives at most one write per processor cycle, and one processor cycle equals three pixel clocks.

Each register is not read continuously. The block copies it into a segment buffer at the instant its segment starts drawing. A write can therefore land between the left-half and right-half draw positions of a register. In that case only the segments not yet started take the new value, and the two halves of the line can differ. The write path has a fixed latency. A write made in pixel clock `w` counts for a segment starting at pixel clock `S` only when `w <= S-3`.

Top module: `pf_scanline_serializer`

## Requirements
- R1: `hcount` is 0 in the first cycle after reset, rises by one each clock and returns from 227 to 0.
- R2: `pf_out` is 0 while `hcount` is in 0..67.
- R3: With the left half (never mirrored), select 0 register bits 4,5,6,7 are drawn from clock 68, select 1 bits 7 down to 0 from clock 84, select 2 bits 0 up to 7 from clock 116, and each bit is held for 4 consecutive clocks.
- R4: With mirroring off, the right half repeats the R3 order starting at clocks 148 (select 0), 164 (select 1) and 196 (select 2).
- R5: With mirroring on, the right half draws select 2 bits 7 down to 0 from clock 148, select 1 bits 0 up to 7 from clock 180, and select 0 bits 7 down to 4 from clock 212.
- R6: A write pulse (`wr_en` high in the cycle where `hcount` = w) reaches the segment that starts at clock S only if w <= S-3. A write at w = S-2 or later leaves that whole segment showing the previous value.
- R7: A late write that misses a segment still appears in later segments of the same line. A select 1 or select 2 rewrite between the two halves gives a line whose right half uses the new value.
- R8: The mirror control is write select 3, bit 0, where 1 means mirrored. It applies to a line's right half only if written at `hcount` <= 145. It never affects the left half.
- R9: Reset clears all registers and the mirror control, and `pf_out` is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe from the processor side |
| wr_sel | input | 2 | Target: 0, 1, 2 pattern registers, 3 control |
| wr_data | input | 8 | Write data |
| hcount | output | 8 | Horizontal pixel position, 0..227 |
| pf_out | output | 1 | Playfield pixel |

## Verification
Fixed register patterns with mirroring off and on are compared pixel by pixel against a behavioural line model. This separates the bit orders and start positions of the three segments in each half. A single-bit pattern per register confirms the segment boundaries directly. Write-time sweeps around each deadline show where the S-3 cutoff lies, and they show that a late write is deferred to the other half rather than lost or partly applied. A mid-line rewrite confirms that the two halves can differ. Writing the mirror control one cycle on either side of its deadline shows that it changes only the right half, of that line or of the next.

// File: rtl/pfs_pkg.sv
// Shared types and bit-order helper for the playfield serializer.
// Assumes three pattern registers plus one control register on a 2-bit select.
package pfs_pkg;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,   // 4-bit pattern, held in bits 7:4
        SEL_MID  = 2'd1,   // 8-bit pattern
        SEL_HI   = 2'd2,   // 8-bit pattern
        SEL_CTL  = 2'd3    // bit 0: mirror right half
    } pf_sel_e;

    // Map the n-th bit shown in a segment to a register bit index.
    function automatic logic [2:0] seg_bit(pf_sel_e kind, logic rev, logic [2:0] n);
        logic [2:0] idx;
        case (kind)
            SEL_LO:  idx = rev ? (3'd7 - n) : (3'd4 + n);
            SEL_MID: idx = rev ? n : (3'd7 - n);
            default: idx = rev ? (3'd7 - n) : n;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/pfs_hcounter.sv
// Horizontal position counter: counts 0..LINE_LEN-1 and wraps.
// Assumes one count per pixel clock and synchronous active-low reset.
module pfs_hcounter #(
    parameter int LINE_LEN = 228,
    parameter int HW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcount
);

    // Advance position, wrap at end of line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcount <= '0;
        else if (int'(hcount) == LINE_LEN - 1)
            hcount <= '0;
        else
            hcount <= hcount + 1'b1;
    end

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hcount) == LINE_LEN - 1) |=> (hcount == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hcount) != LINE_LEN - 1) |=> (hcount == $past(hcount) + 1'b1));

endmodule

// File: rtl/pfs_regfile.sv
// Write staging and live pattern registers.
// A write is captured into a holding stage, then moved into the live register
// one clock later, so a write in cycle w is visible to readers from cycle w+2.
// Assumes at most one write per clock.
module pfs_regfile
    import pfs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NPAT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] reg_lo,
    output logic [DW-1:0] reg_mid,
    output logic [DW-1:0] reg_hi,
    output logic          mirror
);

    logic          hold_valid;
    logic [1:0]    hold_sel;
    logic [DW-1:0] hold_data;
    logic [DW-1:0] pat_q [NPAT];
    logic          mirror_q;

    // Capture an incoming write into the holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_sel   <= '0;
            hold_data  <= '0;
        end else begin
            hold_valid <= wr_en;
            hold_sel   <= wr_sel;
            hold_data  <= wr_data;
        end
    end

    // One live pattern register per select value.
    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        always_ff @(posedge clk) begin
            if (!rst_n)
                pat_q[g] <= '0;
            else if (hold_valid && hold_sel == 2'(g))
                pat_q[g] <= hold_data;
        end
    end

    // Control register keeps only the mirror bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror_q <= 1'b0;
        else if (hold_valid && hold_sel == SEL_CTL)
            mirror_q <= hold_data[0];
    end

    assign reg_lo  = pat_q[0];
    assign reg_mid = pat_q[1];
    assign reg_hi  = pat_q[2];
    assign mirror  = mirror_q;

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_valid);

    a_r6_land_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && hold_sel == SEL_MID) |=> (reg_mid == $past(hold_data)));

    a_r6_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_valid |=> ($stable(reg_lo) && $stable(reg_mid) && $stable(reg_hi) && $stable(mirror)));

endmodule

// File: rtl/pfs_serializer.sv
// Segment scheduler and bit serializer.
// At the clock before each segment starts, the owning register is copied into
// a segment buffer; the buffer then shifts out in the segment's bit order, each
// bit held PPB clocks. The mirror choice for the right half is taken once, at
// the clock before the right half begins. Assumes segments are contiguous.
module pfs_serializer
    import pfs_pkg::*;
#(
    parameter int LINE_LEN = 228,
    parameter int HBLANK   = 68,
    parameter int PPB      = 4,
    parameter int HW       = 8,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcount,
    input  logic [DW-1:0] reg_lo,
    input  logic [DW-1:0] reg_mid,
    input  logic [DW-1:0] reg_hi,
    input  logic          mirror,
    output logic          pf_out
);

    localparam int LO_LEN  = 4 * PPB;
    localparam int WD_LEN  = 8 * PPB;
    localparam int HALF    = LO_LEN + 2 * WD_LEN;
    localparam int L_LO    = HBLANK;
    localparam int L_MID   = HBLANK + LO_LEN;
    localparam int L_HI    = HBLANK + LO_LEN + WD_LEN;
    localparam int R_START = HBLANK + HALF;
    localparam int RN_MID  = R_START + LO_LEN;
    localparam int RN_HI   = R_START + LO_LEN + WD_LEN;
    localparam int RM_MID  = R_START + WD_LEN;
    localparam int RM_LO   = R_START + 2 * WD_LEN;
    localparam int PW      = (PPB > 1) ? $clog2(PPB) : 1;

    int           nxt;
    logic         start_now;
    pf_sel_e      start_kind;
    logic         start_rev;
    logic         half_rev;
    logic         seg_active;
    logic [DW-1:0] seg_buf;
    pf_sel_e      seg_kind;
    logic         seg_rev;
    logic [PW-1:0] pix_cnt;
    logic [2:0]   bit_cnt;

    // Decide whether a segment begins on the next clock, and which.
    always_comb begin
        nxt        = int'(hcount) + 1;
        start_now  = 1'b1;
        start_kind = SEL_LO;
        start_rev  = 1'b0;
        if (nxt == L_LO)
            start_kind = SEL_LO;
        else if (nxt == L_MID)
            start_kind = SEL_MID;
        else if (nxt == L_HI)
            start_kind = SEL_HI;
        else if (nxt == R_START) begin
            start_kind = mirror ? SEL_HI : SEL_LO;
            start_rev  = mirror;
        end else if (!half_rev && nxt == RN_MID)
            start_kind = SEL_MID;
        else if (!half_rev && nxt == RN_HI)
            start_kind = SEL_HI;
        else if (half_rev && nxt == RM_MID) begin
            start_kind = SEL_MID;
            start_rev  = 1'b1;
        end else if (half_rev && nxt == RM_LO) begin
            start_kind = SEL_LO;
            start_rev  = 1'b1;
        end else
            start_now  = 1'b0;
    end

    // Hold the right-half mirror choice for the rest of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_rev <= 1'b0;
        else if (nxt == R_START)
            half_rev <= mirror;
    end

    // Load the segment buffer at segment start and step through its bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_active <= 1'b0;
            seg_buf    <= '0;
            seg_kind   <= SEL_LO;
            seg_rev    <= 1'b0;
            pix_cnt    <= '0;
            bit_cnt    <= '0;
        end else if (start_now) begin
            seg_active <= 1'b1;
            seg_kind   <= start_kind;
            seg_rev    <= start_rev;
            pix_cnt    <= '0;
            bit_cnt    <= '0;
            case (start_kind)
                SEL_LO:  seg_buf <= reg_lo;
                SEL_MID: seg_buf <= reg_mid;
                default: seg_buf <= reg_hi;
            endcase
        end else if (int'(hcount) == LINE_LEN - 1) begin
            seg_active <= 1'b0;
        end else if (seg_active) begin
            if (int'(pix_cnt) == PPB - 1) begin
                pix_cnt <= '0;
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                pix_cnt <= pix_cnt + 1'b1;
            end
        end
    end

    // Pick the current bit out of the segment buffer.
    always_comb begin
        pf_out = seg_active & seg_buf[seg_bit(seg_kind, seg_rev, bit_cnt)];
    end

    a_r2_blank_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hcount) < HBLANK) |-> !seg_active);

    a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_active && pix_cnt != '0) |-> (pf_out == $past(pf_out)));

    a_r6_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !start_now |=> $stable(seg_buf));

    a_r8_half_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt != R_START) |=> $stable(half_rev));

endmodule

// File: rtl/pf_scanline_serializer.sv
// Top: scanline playfield serializer.
// Combines the horizontal counter, the staged register file and the segment
// serializer. Assumes the pixel clock drives everything and the processor
// side issues single-cycle write strobes.
module pf_scanline_serializer #(
    parameter int LINE_LEN = 228,
    parameter int HBLANK   = 68,
    parameter int PPB      = 4,
    parameter int DW       = 8,
    localparam int HW      = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [HW-1:0] hcount,
    output logic          pf_out
);

    logic [DW-1:0] reg_lo;
    logic [DW-1:0] reg_mid;
    logic [DW-1:0] reg_hi;
    logic          mirror;

    pfs_hcounter #(.LINE_LEN(LINE_LEN), .HW(HW)) u_hcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hcount (hcount)
    );

    pfs_regfile #(.DW(DW), .NPAT(3)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .reg_lo  (reg_lo),
        .reg_mid (reg_mid),
        .reg_hi  (reg_hi),
        .mirror  (mirror)
    );

    pfs_serializer #(
        .LINE_LEN (LINE_LEN),
        .HBLANK   (HBLANK),
        .PPB      (PPB),
        .HW       (HW),
        .DW       (DW)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .hcount  (hcount),
        .reg_lo  (reg_lo),
        .reg_mid (reg_mid),
        .reg_hi  (reg_hi),
        .mirror  (mirror),
        .pf_out  (pf_out)
    );

    a_r9_reset_dark: assert property (@(posedge clk)
        !rst_n |=> !pf_out);

endmodule

// File: tb/pf_scanline_serializer_bench.sv
module pf_scanline_serializer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] hcount;
    logic       pf_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pf_scanline_serializer u_pf_scanline_serializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .hcount  (hcount),
        .pf_out  (pf_out)
    );

    // Behavioural reference model state
    typedef struct { int t; int sel; int d; } wr_t;
    wr_t  pend[$];
    int   abs_c = 0;
    int   m_h = 0;
    logic [7:0] r_reg [4];
    logic [7:0] snap [3];
    logic m_rev = 1'b0;
    int   prev_k = -1;
    logic line_bits [228];

    initial begin
        for (int i = 0; i < 4; i++) r_reg[i] = 8'h00;
        for (int i = 0; i < 3; i++) snap[i] = 8'h00;
        for (int i = 0; i < 228; i++) line_bits[i] = 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            abs_c <= 0;
            m_h   <= 0;
        end else begin
            abs_c <= abs_c + 1;
            m_h   <= (m_h == 227) ? 0 : m_h + 1;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int x, half, qi, di, k, b;
            logic rv, e;
            string tag;
            while (pend.size() > 0 && pend[0].t <= abs_c - 3) begin
                r_reg[pend[0].sel] = 8'(pend[0].d);
                void'(pend.pop_front());
            end
            n_chk++;
            if (int'(hcount) != m_h) begin
                n_bad++;
                $display("FAIL R1 hcount actual=%0d expected=%0d", hcount, m_h);
            end
            if (m_h < 68) begin
                e = 1'b0; tag = "R2"; prev_k = -1;
            end else begin
                x = m_h - 68;
                half = x / 80;
                qi = (x % 80) / 4;
                if (half == 1 && (x % 80) == 0) m_rev = r_reg[3][0];
                rv = (half == 1) && m_rev;
                di = rv ? 19 - qi : qi;
                if (di < 4) begin k = 0; b = 4 + di; end
                else if (di < 12) begin k = 1; b = 7 - (di - 4); end
                else begin k = 2; b = di - 12; end
                if ((x % 80) == 0 || k != prev_k) snap[k] = r_reg[k];
                prev_k = k;
                e = snap[k][b];
                tag = (half == 0) ? "R3" : (rv ? "R5" : "R4");
            end
            n_chk++;
            if (pf_out !== e) begin
                n_bad++;
                $display("FAIL %s pf_out at h=%0d actual=%0b expected=%0b", tag, m_h, pf_out, e);
            end
            line_bits[m_h] = pf_out;
        end
    end

    task automatic wr(input int sel, input int data, input int h);
        while (m_h != h) @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
        pend.push_back('{abs_c, sel, data});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int a, input int b, input int c, input int ctl);
        wr(0, a, 2); wr(1, b, 6); wr(2, c, 10); wr(3, ctl, 14);
    endtask

    task automatic end_line();
        @(negedge clk);
        while (m_h != 1) @(negedge clk);
    endtask

    task automatic chk_range(input int lo, input int hi, input logic v, input string tag);
        for (int i = lo; i <= hi; i++) begin
            n_chk++;
            if (line_bits[i] !== v) begin
                n_bad++;
                $display("FAIL %s pixel %0d actual=%0b expected=%0b", tag, i, line_bits[i], v);
            end
        end
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (pf_out !== 1'b0 || hcount !== 8'd0) begin
            n_bad++;
            $display("FAIL R9 reset pf_out/hcount actual=%0b/%0d expected=0/0", pf_out, hcount);
        end
        rst_n = 1'b1;
        end_line();

        // R3: single-bit markers at segment boundaries
        cfg(8'h10, 8'h80, 8'h01, 0);
        end_line();
        chk_range(68, 71, 1'b1, "R3"); chk_range(72, 83, 1'b0, "R3");
        chk_range(84, 87, 1'b1, "R3"); chk_range(88, 115, 1'b0, "R3");
        chk_range(116, 119, 1'b1, "R3"); chk_range(120, 147, 1'b0, "R3");
        chk_range(148, 151, 1'b1, "R4");

        // R3 R4 R5: mixed patterns, compared by the model
        cfg(8'hA0, 8'h3C, 8'hC5, 0); end_line();
        cfg(8'h50, 8'hE1, 8'h2B, 1); end_line();
        cfg(8'hF0, 8'h96, 8'h71, 1); end_line();

        // R6 R7: deadline sweeps per register
        for (int w = 64; w <= 66; w++) begin
            cfg(0, 0, 0, 0); wr(0, 8'hF0, w); end_line();
            chk_range(68, 83, (w <= 65), "R6");
            chk_range(148, 163, 1'b1, "R7");
        end
        for (int w = 79; w <= 83; w++) begin
            cfg(0, 0, 0, 0); wr(1, 8'hFF, w); end_line();
            chk_range(84, 115, (w <= 81), "R6");
            chk_range(164, 195, 1'b1, "R7");
        end
        for (int w = 112; w <= 114; w++) begin
            cfg(0, 0, 0, 0); wr(2, 8'hFF, w); end_line();
            chk_range(116, 147, (w <= 113), "R6");
            chk_range(196, 227, 1'b1, "R7");
        end
        // R6: mirrored right-half deadlines (mid at 180, low at 212)
        for (int w = 177; w <= 178; w++) begin
            cfg(0, 0, 0, 1); wr(1, 8'hFF, w); end_line();
            chk_range(180, 211, (w <= 177), "R6");
        end
        for (int w = 209; w <= 210; w++) begin
            cfg(0, 0, 0, 1); wr(0, 8'hF0, w); end_line();
            chk_range(212, 227, (w <= 209), "R6");
        end

        // R7: asymmetric line from a mid-line rewrite
        cfg(0, 8'h0F, 0, 0); wr(1, 8'hF0, 120); end_line();
        chk_range(84, 99, 1'b0, "R7"); chk_range(100, 115, 1'b1, "R7");
        chk_range(164, 179, 1'b1, "R7"); chk_range(180, 195, 1'b0, "R7");

        // R8: mirror control deadline
        for (int w = 145; w <= 146; w++) begin
            cfg(0, 0, 8'h80, 0); wr(3, 1, w); end_line();
            chk_range(148, 151, (w == 145), "R8");
            chk_range(224, 227, (w != 145), "R8");
            end_line();
            chk_range(144, 147, 1'b1, "R8");
            chk_range(148, 151, 1'b1, "R8");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule